// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block is the bus-facing half of an SPI master. A host reaches it through a simple 32-bit read/write port with byte enables. Behind that port sit a control register, a sticky status register with write-one-to-clear bits, an interrupt mask, a command register, a transmit and a receive window, and one stored mode word per slave select. Two 32-byte FIFOs connect the host to a byte-serial engine. The engine is a stub: it moves one byte per cycle from the transmit FIFO to the receive FIFO until a programmed byte count is used up.

Software turns the block on, writes whole words into the transmit window, and writes the command register to start a transfer of N bytes to one select. It then drains received bytes either four at a time or one at a time. The status register shows the live byte count of both FIFOs next to two threshold-driven flags, and the flags reach the `irq` output through the mask. The engine is a three-state machine. It has idle (`ST_IDLE`) and shifting (`ST_SHIFT`) states, plus a stalled state (`ST_STALL`) for when the transmit FIFO is empty or the receive FIFO is full. It takes these transitions: IDLE→SHIFT on an accepted command; SHIFT→IDLE after the last byte; SHIFT→STALL when no byte can move; STALL→SHIFT when one can; any state→IDLE when the block is disabled.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, offset 0x00 reads 0x0000_0403, and offsets 0x04, 0x08, 0x0C and 0x20–0x2C read 0. In that value, 0x04 is a transmit threshold of 4 in bits 13:8 and 0x03 is a receive threshold of 3 in bits 5:0. Also after reset, `irq` is 0 and `sel_n` is all ones.
- R2: The per-select words at 0x20 + 4·k keep what is written to them, one byte lane per byte-enable bit. Unused offsets such as 0x18 read 0.
- R3: A write to offset 0x10 with all four byte enables set pushes four bytes, bits 31:24 first, but only if at least four bytes are free. Any other transmit write is dropped. Status bits 21:16 give the transmit byte count.
- R4: A receive read (offset 0x14) with more than one byte enable set pops up to four bytes. The oldest byte is returned in bits 31:24. Bytes that are missing read as zero, and the count never goes below zero. Status bits 29:24 give the receive byte count.
- R5: A receive read with exactly one byte enable set pops one byte and returns it in bits 7:0.
- R6: Status bit 9 sets when the receive count exceeds the receive threshold. Status bit 8 sets when the free transmit space is at least the transmit threshold. Both are set only while enabled. A 1 written to a bit clears it, but a set condition in the same cycle wins.
- R7: `irq` is high exactly when a status bit is set and its mask bit (bit 9 or bit 8 at offset 0x08) is set.
- R8: Writing offset 0x0C while enabled and idle starts a transfer of (bits 15:0)+1 bytes to the select in bits 31:30, and that select's `sel_n` line goes low. Each byte moves from the transmit FIFO to the receive FIFO. The transfer stalls while the transmit FIFO is empty or the receive FIFO is full.
- R9: With offset 0x00 bit 30 set, each received byte equals the byte sent. Otherwise it is the value of `ser_in`.
- R10: While offset 0x00 bit 31 is clear, both FIFOs are emptied, any transfer is aborted with `sel_n` all ones, and command writes are ignored.
- R11: Neither FIFO count ever exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (receive reads pop at the clock edge) |
| bus_addr | input | 8 | Byte offset |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during the read |
| irq | output | 1 | Masked interrupt |
| ser_in | input | 8 | Byte from the slave when not in loopback |
| ser_out | output | 8 | Byte being sent |
| ser_out_valid | output | 1 | A byte moves this cycle |
| sel_n | output | NUM_SEL | Active-low slave selects |

## Verification
The collision that matters is between a status flag being set and the host clearing it with write-one-to-clear in the same cycle. The bench provokes it by leaving four bytes in the receive FIFO, which is above the threshold of 3, and then writing ones to the status register. It judges the outcome by reading bit 9 back as still 1, then draining the FIFO and clearing again to see the bit fall. A second overlap is a transmit push racing the engine's pop. The bench avoids that race for its count checks and covers it in the RTL checks only when the engine is idle.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_MASK = 8'h08;
    localparam logic [7:0] OFF_CMD  = 8'h0C;
    localparam logic [7:0] OFF_TXW  = 8'h10;
    localparam logic [7:0] OFF_RXW  = 8'h14;

    localparam logic [31:0] CTRL_BITS  = 32'hC000_3F3F;
    localparam logic [31:0] CTRL_RESET = 32'h0000_0403;
    localparam logic [31:0] MASK_BITS  = 32'h0000_0300;
    localparam logic [31:0] CMD_BITS   = 32'hC000_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_STALL
    } eng_state_t;

    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        return r;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_data,
    input  logic [2:0]    pop_n,
    output logic [31:0]   peek,
    output logic [CW-1:0] count
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        for (int k = 0; k < 4; k++)
            if (!flush && k < int'(push_n))
                mem[wr_ptr + AW'(k)] <= push_data[31-8*k -: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_peek
        assign peek[31-8*k -: 8] = (int'(count) > k) ? mem[rd_ptr + AW'(k)] : 8'h00;
    end

    // R11: occupancy stays within the storage
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);
    // R4: the caller never asks for more bytes than are held
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> CW'(pop_n) <= count);
    // R3: a push only arrives when it fits
    a_r3_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 3'd0 && !flush) |-> int'(count) + int'(push_n) <= DEPTH);

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import spi_host_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int LEN_W   = 16,
    localparam int SW = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               loopback,
    input  logic               start,
    input  logic [LEN_W-1:0]   start_len,
    input  logic [SW-1:0]      start_sel,
    input  logic               tx_avail,
    input  logic               rx_room,
    input  logic [7:0]         tx_byte,
    input  logic [7:0]         ser_in,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [7:0]         rx_byte,
    output logic [7:0]         ser_out,
    output logic               ser_out_valid,
    output logic               idle,
    output logic [NUM_SEL-1:0] sel_n
);

    eng_state_t       state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    logic [SW-1:0]    sel_q;
    logic             move;

    assign move = (state_q == ST_SHIFT) && tx_avail && rx_room;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_d = ST_SHIFT;
                ST_SHIFT: begin
                    if (move && rem_q == '0) state_d = ST_IDLE;
                    else if (!move)          state_d = ST_STALL;
                end
                ST_STALL: if (tx_avail && rx_room) state_d = ST_SHIFT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            sel_q <= '0;
        end else if (start && state_q == ST_IDLE) begin
            rem_q <= start_len;
            sel_q <= start_sel;
        end else if (move && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    always_comb begin
        tx_pop        = move;
        rx_push       = move;
        rx_byte       = loopback ? tx_byte : ser_in;
        ser_out       = tx_byte;
        ser_out_valid = move;
        idle          = (state_q == ST_IDLE);
        sel_n         = '1;
        if (state_q != ST_IDLE) sel_n[sel_q] = 1'b0;
    end

    // R8: at most one select is driven
    a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));
    // R10: disabling releases every select on the next cycle
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> sel_n == '1);

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int NUM_SEL    = 4,
    parameter int LEN_W      = 16,
    localparam int CW = $clog2(FIFO_DEPTH + 1),
    localparam int SW = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    input  logic [7:0]         ser_in,
    output logic [7:0]         ser_out,
    output logic               ser_out_valid,
    output logic [NUM_SEL-1:0] sel_n
);

    logic [31:0]   ctrl_q, mask_q, cmd_q, cmd_next;
    logic [31:0]   sel_word [NUM_SEL];
    logic          ev_rx_q, ev_tx_q;
    logic          ctl_en, ctl_loop;
    logic [5:0]    tx_thr, rx_thr;
    logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
    logic [31:0]   tx_peek, rx_peek;
    logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n, rx_want;
    logic          tx_pop, rx_push, eng_idle, one_byte, start;
    logic [7:0]    rx_byte;
    logic          sel_hit, set_rx, set_tx, stat_wr;
    logic [SW-1:0] sel_idx;

    assign ctl_en   = ctrl_q[31];
    assign ctl_loop = ctrl_q[30];
    assign tx_thr   = ctrl_q[13:8];
    assign rx_thr   = ctrl_q[5:0];
    assign tx_free  = CW'(FIFO_DEPTH) - tx_cnt;
    assign one_byte = ($countones(bus_be) == 1);
    assign sel_hit  = (bus_addr[7:4] == 4'h2) && (bus_addr[1:0] == 2'b00);
    assign sel_idx  = bus_addr[SW+1:2];
    assign cmd_next = be_merge(cmd_q, bus_wdata, bus_be) & CMD_BITS;
    assign start    = bus_wr && bus_addr == OFF_CMD && ctl_en && eng_idle;
    assign stat_wr  = bus_wr && bus_addr == OFF_STAT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            mask_q <= '0;
            cmd_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_CTRL)
                ctrl_q <= be_merge(ctrl_q, bus_wdata, bus_be) & CTRL_BITS;
            if (bus_addr == OFF_MASK)
                mask_q <= be_merge(mask_q, bus_wdata, bus_be) & MASK_BITS;
            if (bus_addr == OFF_CMD && ctl_en)
                cmd_q <= cmd_next;
        end
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_selword
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sel_word[g] <= '0;
            else if (bus_wr && sel_hit && sel_idx == SW'(g))
                sel_word[g] <= be_merge(sel_word[g], bus_wdata, bus_be);
        end
    end

    // status flags: a set condition wins over a clear
    assign set_rx = ctl_en && (rx_cnt > CW'(rx_thr));
    assign set_tx = ctl_en && (tx_free >= CW'(tx_thr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_rx_q <= 1'b0;
            ev_tx_q <= 1'b0;
        end else begin
            if (set_rx)                                   ev_rx_q <= 1'b1;
            else if (stat_wr && bus_be[1] && bus_wdata[9]) ev_rx_q <= 1'b0;
            if (set_tx)                                   ev_tx_q <= 1'b1;
            else if (stat_wr && bus_be[1] && bus_wdata[8]) ev_tx_q <= 1'b0;
        end
    end

    assign irq = (ev_rx_q && mask_q[9]) || (ev_tx_q && mask_q[8]);

    // FIFO request sizing
    assign tx_push_n = (bus_wr && bus_addr == OFF_TXW && bus_be == 4'hF &&
                        tx_free >= CW'(4)) ? 3'd4 : 3'd0;
    assign tx_pop_n  = tx_pop ? 3'd1 : 3'd0;
    assign rx_push_n = rx_push ? 3'd1 : 3'd0;
    assign rx_want   = one_byte ? 3'd1 : 3'd4;
    assign rx_pop_n  = !(bus_rd && bus_addr == OFF_RXW) ? 3'd0 :
                       (CW'(rx_want) > rx_cnt) ? rx_cnt[2:0] : rx_want;

    byte_fifo #(.DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!ctl_en),
        .push_n(tx_push_n), .push_data(bus_wdata),
        .pop_n(tx_pop_n), .peek(tx_peek), .count(tx_cnt));

    byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!ctl_en),
        .push_n(rx_push_n), .push_data({rx_byte, 24'h0}),
        .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt));

    xfer_engine #(.NUM_SEL(NUM_SEL), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(ctl_en), .loopback(ctl_loop),
        .start(start), .start_len(cmd_next[LEN_W-1:0]),
        .start_sel(cmd_next[31 -: SW]),
        .tx_avail(tx_cnt != '0), .rx_room(rx_cnt != CW'(FIFO_DEPTH)),
        .tx_byte(tx_peek[31:24]), .ser_in(ser_in),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .ser_out(ser_out), .ser_out_valid(ser_out_valid),
        .idle(eng_idle), .sel_n(sel_n));

    always_comb begin
        bus_rdata = '0;
        if (sel_hit && int'(sel_idx) < NUM_SEL) begin
            bus_rdata = sel_word[sel_idx];
        end else begin
            unique case (bus_addr)
                OFF_CTRL: bus_rdata = ctrl_q;
                OFF_STAT: bus_rdata = {2'b00, 6'(rx_cnt), 2'b00, 6'(tx_cnt),
                                       6'b0, ev_rx_q, ev_tx_q, 8'h00};
                OFF_MASK: bus_rdata = mask_q;
                OFF_CMD:  bus_rdata = cmd_q;
                OFF_RXW:  bus_rdata = one_byte ? {24'h0, rx_peek[31:24]} : rx_peek;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R10: disabled means both FIFOs are empty one cycle later
    a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (tx_cnt == '0 && rx_cnt == '0));
    // R6: an over-threshold receive count leaves the flag set
    a_r6_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_rx |=> ev_rx_q);
    // R7: no interrupt without some mask bit
    a_r7_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q[9] || mask_q[8]));
    // R3: partial transmit writes leave the count unchanged when idle
    a_r3_partial_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_TXW && bus_be != 4'hF && eng_idle && ctl_en)
        |=> tx_cnt == $past(tx_cnt));
    // R5: a single-lane read removes one byte
    a_r5_byte_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_RXW && one_byte && rx_cnt != '0 &&
         !rx_push && ctl_en) |=> rx_cnt == $past(rx_cnt) - 1'b1);

endmodule

// File: tb/spi_host_regs_tb.sv
module spi_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [7:0]  ser_in = 8'hA5;
    logic [7:0]  ser_out;
    logic        ser_out_valid;
    logic [3:0]  sel_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .ser_in(ser_in), .ser_out(ser_out),
        .ser_out_valid(ser_out_valid), .sel_n(sel_n));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(8'h04, 4'hF, v);
            if (int'(v[29:24]) == n) return;
        end
        check("R8 rx count reached", {26'h0, v[29:24]}, n);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, 4'hF, v); check("R1 ctrl reset", v, 32'h0000_0403);
        rd(8'h04, 4'hF, v); check("R1 status reset", v, 32'h0);
        rd(8'h08, 4'hF, v); check("R1 mask reset", v, 32'h0);
        rd(8'h0C, 4'hF, v); check("R1 cmd reset", v, 32'h0);
        rd(8'h2C, 4'hF, v); check("R1 select word reset", v, 32'h0);
        check("R1 irq reset", {31'h0, irq}, 32'h0);
        check("R1 sel_n reset", {28'h0, sel_n}, 32'hF);
    endtask

    task automatic t_selwords;
        logic [31:0] v;
        wr(8'h24, 4'hF, 32'hDEAD_BEEF);
        wr(8'h24, 4'b0010, 32'h0000_5500);
        rd(8'h24, 4'hF, v); check("R2 byte-lane write", v, 32'hDEAD_55EF);
        rd(8'h28, 4'hF, v); check("R2 other word untouched", v, 32'h0);
        rd(8'h18, 4'hF, v); check("R2 unused offset", v, 32'h0);
    endtask

    task automatic t_fill;
        logic [31:0] v;
        wr(8'h00, 4'hF, 32'hC000_0403);
        rd(8'h04, 4'hF, v); check("R6 tx room flag after enable", v, 32'h0000_0100);
        wr(8'h10, 4'hF, 32'h1122_3344);
        rd(8'h04, 4'hF, v); check("R3 tx count after push", {26'h0, v[21:16]}, 32'd4);
        wr(8'h10, 4'b0011, 32'hFFFF_FFFF);
        rd(8'h04, 4'hF, v); check("R3 partial write dropped", {26'h0, v[21:16]}, 32'd4);
        for (int i = 0; i < 7; i++) wr(8'h10, 4'hF, 32'h1122_3344);
        wr(8'h10, 4'hF, 32'h9999_9999);
        rd(8'h04, 4'hF, v); check("R11 full tx count capped", {26'h0, v[21:16]}, 32'd32);
        wr(8'h04, 4'hF, 32'hFFFF_FFFF);
        rd(8'h04, 4'hF, v); check("R6 w1c clears tx flag when full", v, 32'h0020_0000);
    endtask

    task automatic t_loop_word;
        logic [31:0] v;
        wr(8'h0C, 4'hF, 32'h8000_0003);
        @(negedge clk);
        check("R8 select 2 driven", {28'h0, sel_n}, 32'hB);
        wait_rx(4);
        rd(8'h04, 4'hF, v); check("R6 R8 status after 4 bytes", v, 32'h041C_0300);
        wr(8'h08, 4'hF, 32'h0000_0200);
        @(negedge clk);
        check("R7 irq with mask", {31'h0, irq}, 32'h1);
        rd(8'h14, 4'hF, v); check("R4 R9 word read loopback", v, 32'h1122_3344);
        wr(8'h04, 4'hF, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R7 irq after clear", {31'h0, irq}, 32'h0);
        rd(8'h04, 4'hF, v); check("R6 tx flag re-sets", v, 32'h001C_0100);
    endtask

    task automatic t_byte_read;
        logic [31:0] v;
        wr(8'h0C, 4'hF, 32'h0000_0002);
        wait_rx(3);
        rd(8'h14, 4'b0001, v); check("R5 byte read value", v, 32'h0000_0011);
        rd(8'h04, 4'hF, v); check("R5 one byte removed", {26'h0, v[29:24]}, 32'd2);
        rd(8'h14, 4'hF, v); check("R4 short read zero fill", v, 32'h2233_0000);
        rd(8'h14, 4'hF, v); check("R4 empty read", v, 32'h0);
        rd(8'h04, 4'hF, v); check("R4 no underflow", {26'h0, v[29:24]}, 32'd0);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        wr(8'h0C, 4'hF, 32'h0000_0003);
        wait_rx(4);
        wr(8'h04, 4'hF, 32'h0000_0200);
        rd(8'h04, 4'hF, v); check("R6 set wins over clear", {31'h0, v[9]}, 32'h1);
        rd(8'h14, 4'hF, v); check("R9 loopback order", v, 32'h4411_2233);
        wr(8'h04, 4'hF, 32'h0000_0200);
        rd(8'h04, 4'hF, v); check("R6 clear once drained", {31'h0, v[9]}, 32'h0);
    endtask

    task automatic t_no_loop;
        logic [31:0] v;
        wr(8'h00, 4'hF, 32'h8000_0403);
        wr(8'h0C, 4'hF, 32'h0000_0001);
        wait_rx(2);
        rd(8'h14, 4'hF, v); check("R9 bytes from ser_in", v, 32'hA5A5_0000);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        wr(8'h0C, 4'hF, 32'h0000_0063);
        wait_rx(19);
        check("R8 stalled transfer keeps select 0", {28'h0, sel_n}, 32'hE);
        wr(8'h00, 4'hF, 32'h0000_0403);
        @(negedge clk);
        check("R10 select released", {28'h0, sel_n}, 32'hF);
        rd(8'h04, 4'hF, v); check("R10 FIFOs flushed", v & 32'h3F3F_0000, 32'h0);
        wr(8'h0C, 4'hF, 32'h0000_0001);
        @(negedge clk);
        check("R10 command ignored when off", {28'h0, sel_n}, 32'hF);
        wr(8'h00, 4'hF, 32'hC000_0403);
        @(negedge clk);
        check("R10 no transfer on re-enable", {28'h0, sel_n}, 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_selwords();
        t_fill();
        t_loop_word();
        t_byte_read();
        t_collision();
        t_no_loop();
        t_disable();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule